// File: doc/BRIEF.md
# Scratchpad Refresh Command Handler

This block runs one command of a byte-level slave: the refresh of an eight-byte scratchpad row from memory. It waits in idle for the command byte A3h. The master then sends the target address as two bytes. If the address is in range, the block clears the scratchpad status and takes master data bytes. Each data byte fetches the memory byte at the matching position of the addressed row and loads it into the scratchpad. After the eighth byte the block returns an inverted CRC16 over every byte the master sent, and after that it returns all-ones.

A reset or abort strobe from the master returns the handler to idle at any point. If the strobe arrives while a byte is only partly shifted in during the data phase, the partial-byte flag is raised. An authorization flag is raised at the end of a completed refresh, but only for targets in the lower address region. The scratchpad row, the status fields and a byte read port are brought out for the neighbouring command logic. The memory is external and answers one cycle after each read strobe.

Top module: `scratch_refresh`

## Requirements
- R1: After rst_n is released: cmd_active=0, st_count=0, st_offset=0, st_ending=0, st_pf=0, st_aa=0, every scratchpad byte reads 00h, and tx_data=FFh.
- R2: In idle, only a received byte equal to A3h starts the command (cmd_active goes to 1). Any other byte leaves cmd_active at 0.
- R3: The first byte after the command is the low address byte and the second is the high byte. Together they appear on st_target as {high, low}.
- R4: If the target is below 0090h, the high address byte clears st_count, st_pf and st_aa, sets st_offset to 000, and sets st_ending to 111.
- R5: If the target is 0090h or above, the command is not executed. tx_data stays FFh, and later data bytes change neither the status fields nor the scratchpad.
- R6: Each data byte in the data phase pulses mem_ren for one cycle with mem_addr = {st_target[15:3], st_count}. The byte mem_rdata returns in the next cycle is written to scratchpad[st_count]. st_count then increments, and it holds at 7 when the eighth byte ends the data phase.
- R7: After the eighth data byte, each tx_req returns a byte of the CRC16. The CRC uses polynomial x^16+x^15+x^2+1, takes bits LSB-first from an initial value of 0000h, and is computed over the command byte, both address bytes and the eight data bytes as they were received. The value is inverted and returned low byte first.
- R8: After the two CRC bytes, tx_data reads FFh, and received bytes are ignored until mst_reset.
- R9: When the eighth data byte is accepted, st_aa is set if the target is 007Fh or lower. Otherwise st_aa stays 0.
- R10: mst_reset while rx_partial=1 in the data phase sets st_pf. A reset at any other time leaves st_pf unchanged.
- R11: mst_reset returns the handler to idle from any state (cmd_active=0, tx_data=FFh). Scratchpad bytes already loaded are kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mst_reset | input | 1 | Master reset/abort strobe, one cycle |
| rx_valid | input | 1 | A complete byte from the master is on rx_data |
| rx_data | input | 8 | Byte received from the master |
| rx_partial | input | 1 | Some bits of a byte are in flight but the byte is not complete |
| tx_req | input | 1 | Master consumes the byte on tx_data |
| tx_data | output | 8 | Byte returned to the master |
| mem_ren | output | 1 | Memory read strobe |
| mem_addr | output | 16 | Memory read address |
| mem_rdata | input | 8 | Memory data, valid one cycle after mem_ren |
| sp_raddr | input | 3 | Scratchpad read index |
| sp_rdata | output | 8 | Scratchpad byte at sp_raddr |
| st_target | output | 16 | Received target address |
| st_count | output | 3 | Scratchpad byte counter |
| st_offset | output | 3 | Offset field of the target |
| st_ending | output | 3 | Ending-offset field |
| st_pf | output | 1 | Partial-byte flag |
| st_aa | output | 1 | Authorization flag |
| cmd_active | output | 1 | Handler is outside idle |

## Verification
The state that is hardest to reach from the ports is an abort in the middle of a row. The strobe has to land while rx_partial is high after only some data bytes have been loaded, and the bench must then show that the flag rose while the loaded bytes and the older bytes beyond them both survived. The bench gets there by filling the whole row with a first command, then starting a second command on a different row and aborting after three bytes. The two generations of scratchpad content then tell the kept bytes from the newly loaded ones. Rejected addresses come straight after executed ones in the vector table, so the status left by the previous command can be checked for being untouched.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TA_LO,
    ST_TA_HI,
    ST_LOAD,
    ST_CRC_LO,
    ST_CRC_HI,
    ST_ONES
  } rfs_state_e;

  localparam logic [15:0] CRC_POLY_REFL = 16'hA001;

  // One byte into a reflected CRC16, least significant bit first.
  function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    logic        fb;
    r = c;
    for (int i = 0; i < 8; i++) begin
      fb = r[0] ^ d[i];
      r  = {1'b0, r[15:1]};
      if (fb) r = r ^ CRC_POLY_REFL;
    end
    return r;
  endfunction

  // Byte returned to the master for a given state.
  function automatic logic [7:0] tx_select(input rfs_state_e s, input logic [15:0] crc);
    case (s)
      ST_CRC_LO: return ~crc[7:0];
      ST_CRC_HI: return ~crc[15:8];
      default:   return 8'hFF;
    endcase
  endfunction

endpackage

// File: rtl/rfs_crc16.sv
module rfs_crc16 (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        upd,
  input  logic [7:0]  din,
  output logic [15:0] crc
);
  import rfs_pkg::*;

  logic [15:0] crc_q;
  logic [15:0] base;

  assign base = start ? 16'h0000 : crc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   crc_q <= 16'h0000;
    else if (upd) crc_q <= crc16_step(base, din);
  end

  assign crc = crc_q;
endmodule

// File: rtl/rfs_scratch.sv
module rfs_scratch #(
  parameter int ROW_BYTES = 8,
  localparam int CW = $clog2(ROW_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          entry_clr,
  input  logic          take,
  input  logic [7:0]    load_data,
  input  logic          set_pf,
  input  logic          set_aa,
  input  logic [CW-1:0] rd_idx,
  output logic [7:0]    rd_data,
  output logic [CW-1:0] count,
  output logic [CW-1:0] offset,
  output logic [CW-1:0] ending,
  output logic          pf,
  output logic          aa
);
  localparam logic [CW-1:0] LAST = CW'(ROW_BYTES - 1);

  logic [CW-1:0] count_q, offset_q, ending_q;
  logic          pf_q, aa_q;
  logic          pend_q;
  logic [CW-1:0] pend_idx_q;
  logic [7:0]    sp_q [ROW_BYTES];

  // Remember which slot the read in flight belongs to.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= 1'b0;
      pend_idx_q <= '0;
    end else begin
      pend_q     <= take;
      pend_idx_q <= count_q;
    end
  end

  for (genvar g = 0; g < ROW_BYTES; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        sp_q[g] <= 8'h00;
      else if (pend_q && pend_idx_q == CW'(g))
        sp_q[g] <= load_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q  <= '0;
      offset_q <= '0;
      ending_q <= '0;
      pf_q     <= 1'b0;
      aa_q     <= 1'b0;
    end else begin
      if (entry_clr) begin
        count_q  <= '0;
        offset_q <= '0;
        ending_q <= LAST;
        pf_q     <= 1'b0;
        aa_q     <= 1'b0;
      end else begin
        if (take && count_q != LAST) count_q <= count_q + 1'b1;
        if (set_pf) pf_q <= 1'b1;
        if (set_aa) aa_q <= 1'b1;
      end
    end
  end

  assign rd_data = sp_q[rd_idx];
  assign count   = count_q;
  assign offset  = offset_q;
  assign ending  = ending_q;
  assign pf      = pf_q;
  assign aa      = aa_q;
endmodule

// File: rtl/rfs_ctrl.sv
module rfs_ctrl #(
  parameter int          ROW_BYTES  = 8,
  parameter logic [7:0]  CMD_CODE   = 8'hA3,
  parameter logic [15:0] EXEC_LIMIT = 16'h0090,
  parameter logic [15:0] AUTH_MAX   = 16'h007F,
  localparam int CW = $clog2(ROW_BYTES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mst_reset,
  input  logic                rx_valid,
  input  logic [7:0]          rx_data,
  input  logic                rx_partial,
  input  logic                tx_req,
  input  logic [CW-1:0]       count,
  output rfs_pkg::rfs_state_e state,
  output logic [15:0]         target,
  output logic                ev_cmd,
  output logic                ev_addr_ok,
  output logic                ev_addr_bad,
  output logic                ev_take,
  output logic                ev_last,
  output logic                ev_set_pf,
  output logic                ev_set_aa,
  output logic                crc_upd
);
  import rfs_pkg::*;

  localparam logic [CW-1:0] LAST = CW'(ROW_BYTES - 1);

  rfs_state_e  state_q, state_d;
  logic [15:0] target_q;
  logic [15:0] addr_full;
  logic        live;

  assign live      = !mst_reset;
  assign addr_full = {rx_data, target_q[7:0]};

  assign ev_cmd      = live && state_q == ST_IDLE  && rx_valid && rx_data == CMD_CODE;
  assign ev_addr_ok  = live && state_q == ST_TA_HI && rx_valid && addr_full <  EXEC_LIMIT;
  assign ev_addr_bad = live && state_q == ST_TA_HI && rx_valid && addr_full >= EXEC_LIMIT;
  assign ev_take     = live && state_q == ST_LOAD  && rx_valid;
  assign ev_last     = ev_take && count == LAST;
  assign ev_set_pf   = mst_reset && state_q == ST_LOAD && rx_partial;
  assign ev_set_aa   = ev_last && target_q <= AUTH_MAX;
  assign crc_upd     = ev_cmd || ev_take ||
                       (live && rx_valid && (state_q == ST_TA_LO || state_q == ST_TA_HI));

  always_comb begin
    state_d = state_q;
    if (mst_reset) begin
      state_d = ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE:   if (ev_cmd)   state_d = ST_TA_LO;
        ST_TA_LO:  if (rx_valid) state_d = ST_TA_HI;
        ST_TA_HI:  if (rx_valid) state_d = ev_addr_ok ? ST_LOAD : ST_ONES;
        ST_LOAD:   if (ev_last)  state_d = ST_CRC_LO;
        ST_CRC_LO: if (tx_req)   state_d = ST_CRC_HI;
        ST_CRC_HI: if (tx_req)   state_d = ST_ONES;
        default:                 state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      target_q <= 16'h0000;
    end else begin
      state_q <= state_d;
      if (live && rx_valid && state_q == ST_TA_LO) target_q[7:0]  <= rx_data;
      if (live && rx_valid && state_q == ST_TA_HI) target_q[15:8] <= rx_data;
    end
  end

  assign state  = state_q;
  assign target = target_q;
endmodule

// File: rtl/scratch_refresh.sv
module scratch_refresh #(
  parameter int          ROW_BYTES  = 8,
  parameter logic [7:0]  CMD_CODE   = 8'hA3,
  parameter logic [15:0] EXEC_LIMIT = 16'h0090,
  parameter logic [15:0] AUTH_MAX   = 16'h007F,
  localparam int CW = $clog2(ROW_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mst_reset,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  input  logic          rx_partial,
  input  logic          tx_req,
  output logic [7:0]    tx_data,
  output logic          mem_ren,
  output logic [15:0]   mem_addr,
  input  logic [7:0]    mem_rdata,
  input  logic [CW-1:0] sp_raddr,
  output logic [7:0]    sp_rdata,
  output logic [15:0]   st_target,
  output logic [CW-1:0] st_count,
  output logic [CW-1:0] st_offset,
  output logic [CW-1:0] st_ending,
  output logic          st_pf,
  output logic          st_aa,
  output logic          cmd_active
);
  import rfs_pkg::*;

  rfs_state_e  state;
  logic [15:0] target;
  logic [15:0] crc;
  logic        ev_cmd, ev_addr_ok, ev_addr_bad, ev_take, ev_last;
  logic        ev_set_pf, ev_set_aa, crc_upd;
  logic        st_is_ones, st_is_crc_lo;

  rfs_ctrl #(
    .ROW_BYTES(ROW_BYTES), .CMD_CODE(CMD_CODE),
    .EXEC_LIMIT(EXEC_LIMIT), .AUTH_MAX(AUTH_MAX)
  ) i_ctrl (
    .clk(clk), .rst_n(rst_n), .mst_reset(mst_reset),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_partial(rx_partial),
    .tx_req(tx_req), .count(st_count), .state(state), .target(target),
    .ev_cmd(ev_cmd), .ev_addr_ok(ev_addr_ok), .ev_addr_bad(ev_addr_bad),
    .ev_take(ev_take), .ev_last(ev_last), .ev_set_pf(ev_set_pf),
    .ev_set_aa(ev_set_aa), .crc_upd(crc_upd)
  );

  rfs_crc16 i_crc (
    .clk(clk), .rst_n(rst_n), .start(ev_cmd), .upd(crc_upd),
    .din(rx_data), .crc(crc)
  );

  rfs_scratch #(.ROW_BYTES(ROW_BYTES)) i_scratch (
    .clk(clk), .rst_n(rst_n), .entry_clr(ev_addr_ok), .take(ev_take),
    .load_data(mem_rdata), .set_pf(ev_set_pf), .set_aa(ev_set_aa),
    .rd_idx(sp_raddr), .rd_data(sp_rdata), .count(st_count),
    .offset(st_offset), .ending(st_ending), .pf(st_pf), .aa(st_aa)
  );

  assign st_is_ones   = state == ST_ONES;
  assign st_is_crc_lo = state == ST_CRC_LO;
  assign tx_data      = tx_select(state, crc);
  assign mem_ren      = ev_take;
  assign mem_addr     = {target[15:CW], st_count};
  assign st_target    = target;
  assign cmd_active   = state != ST_IDLE;
endmodule

// File: rtl/rfs_checker.sv
module rfs_checker #(
  parameter int          ROW_BYTES = 8,
  parameter logic [15:0] AUTH_MAX  = 16'h007F,
  localparam int CW = $clog2(ROW_BYTES)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mst_reset,
  input logic          rx_partial,
  input logic [7:0]    tx_data,
  input logic [15:0]   st_target,
  input logic [CW-1:0] st_count,
  input logic [CW-1:0] st_offset,
  input logic [CW-1:0] st_ending,
  input logic          st_pf,
  input logic          st_aa,
  input logic          cmd_active,
  input logic          ev_addr_ok,
  input logic          ev_addr_bad,
  input logic          ev_take,
  input logic          ev_last,
  input logic          st_is_ones,
  input logic          st_is_crc_lo
);
  localparam logic [CW-1:0] LAST = CW'(ROW_BYTES - 1);

  AST_ENTRY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_addr_ok |=> (st_count == '0 && !st_pf && !st_aa && st_offset == '0 && st_ending == LAST)); // R4
  AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ev_addr_bad |=> (tx_data == 8'hFF && $stable(st_count) && $stable(st_aa) && $stable(st_pf))); // R5
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_take && st_count != LAST) |=> st_count == $past(st_count) + 1'b1); // R6
  AST_ROW_TO_CRC: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_last && !mst_reset) |=> st_is_crc_lo); // R6
  AST_ONES_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
    st_is_ones |-> tx_data == 8'hFF); // R8
  AST_AA_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_aa) |-> st_target <= AUTH_MAX); // R9
  AST_PF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_pf) |-> $past(mst_reset && rx_partial)); // R10
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    mst_reset |=> !cmd_active); // R11
endmodule

bind scratch_refresh rfs_checker #(.ROW_BYTES(ROW_BYTES), .AUTH_MAX(AUTH_MAX)) i_chk (
  .clk(clk), .rst_n(rst_n), .mst_reset(mst_reset), .rx_partial(rx_partial),
  .tx_data(tx_data), .st_target(st_target), .st_count(st_count),
  .st_offset(st_offset), .st_ending(st_ending), .st_pf(st_pf), .st_aa(st_aa),
  .cmd_active(cmd_active), .ev_addr_ok(ev_addr_ok), .ev_addr_bad(ev_addr_bad),
  .ev_take(ev_take), .ev_last(ev_last), .st_is_ones(st_is_ones),
  .st_is_crc_lo(st_is_crc_lo)
);

// File: tb/test_scratch_refresh.sv
module test_scratch_refresh;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mst_reset = 1'b0, rx_valid = 1'b0, rx_partial = 1'b0, tx_req = 1'b0;
  logic [7:0]  rx_data = 8'h00;
  logic [7:0]  tx_data, mem_rdata = 8'h00, sp_rdata;
  logic        mem_ren, st_pf, st_aa, cmd_active;
  logic [15:0] mem_addr, st_target;
  logic [2:0]  sp_raddr = 3'd0, st_count, st_offset, st_ending;

  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;
  logic [7:0] exp_sp [8];
  logic       prev_aa;

  always #5 clk = ~clk;

  scratch_refresh i_scratch_refresh (
    .clk(clk), .rst_n(rst_n), .mst_reset(mst_reset), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_partial(rx_partial), .tx_req(tx_req), .tx_data(tx_data),
    .mem_ren(mem_ren), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .sp_raddr(sp_raddr), .sp_rdata(sp_rdata), .st_target(st_target),
    .st_count(st_count), .st_offset(st_offset), .st_ending(st_ending),
    .st_pf(st_pf), .st_aa(st_aa), .cmd_active(cmd_active)
  );

  function automatic logic [7:0] memval(input logic [15:0] a);
    return (a[7:0] * 8'd29) ^ a[15:8] ^ 8'hC3;
  endfunction

  always @(posedge clk) if (mem_ren) mem_rdata <= memval(mem_addr);

  function automatic logic [15:0] crc_add(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c ^ {8'h00, b};
    for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 16'hA001) : (r >> 1);
    return r;
  endfunction

  typedef struct packed {
    logic [15:0] addr;
    logic [7:0]  seed;
    logic        exec;
    logic        aa;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{16'h0000, 8'h10, 1'b1, 1'b1},
    '{16'h0023, 8'h3C, 1'b1, 1'b1},
    '{16'h007F, 8'hE0, 1'b1, 1'b1},
    '{16'h0090, 8'h01, 1'b0, 1'b0},
    '{16'h0080, 8'h77, 1'b1, 1'b0},
    '{16'h008F, 8'hA5, 1'b1, 1'b0},
    '{16'h1234, 8'h55, 1'b0, 1'b0}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_data = b;
    @(negedge clk); rx_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic recv(output logic [7:0] b);
    @(negedge clk); b = tx_data; tx_req = 1'b1;
    @(negedge clk); tx_req = 1'b0;
  endtask

  task automatic abort(input logic partial);
    @(negedge clk); mst_reset = 1'b1; rx_partial = partial;
    @(negedge clk); mst_reset = 1'b0; rx_partial = 1'b0;
  endtask

  task automatic sp_match(input string tag);
    logic ok;
    logic [7:0] bad_a, bad_e;
    ok = 1'b1; bad_a = 8'h00; bad_e = 8'h00;
    for (int i = 0; i < 8; i++) begin
      sp_raddr = 3'(i); #1;
      if (sp_rdata !== exp_sp[i]) begin ok = 1'b0; bad_a = sp_rdata; bad_e = exp_sp[i]; end
    end
    chk(ok, tag, {24'h0, bad_a}, {24'h0, bad_e});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] crc;
    logic [7:0]  b;
    for (int i = 0; i < 8; i++) exp_sp[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk({cmd_active, st_count, st_offset, st_ending, st_pf, st_aa} == 12'h0, "R1 status",
        {20'h0, cmd_active, st_count, st_offset, st_ending, st_pf, st_aa}, 0);
    chk(tx_data == 8'hFF, "R1 tx", {24'h0, tx_data}, 32'hFF);
    sp_match("R1 scratchpad");

    // R2 only the command code leaves idle
    send(8'h55); send(8'hF0);
    chk(!cmd_active, "R2 other byte ignored", {31'h0, cmd_active}, 0);
    send(8'hA3);
    chk(cmd_active, "R2 command starts", {31'h0, cmd_active}, 1);
    abort(1'b0);

    prev_aa = 1'b0;
    foreach (VECS[v]) begin
      abort(1'b0);
      send(8'hA3); send(VECS[v].addr[7:0]); send(VECS[v].addr[15:8]);
      chk(st_target == VECS[v].addr, "R3 target", {16'h0, st_target}, {16'h0, VECS[v].addr});
      if (VECS[v].exec) begin
        chk({st_count, st_pf, st_aa, st_offset, st_ending} == {3'd0, 1'b0, 1'b0, 3'd0, 3'd7},
            "R4 entry status", {21'h0, st_count, st_pf, st_aa, st_offset, st_ending}, 32'h7);
        crc = crc_add(16'h0000, 8'hA3);
        crc = crc_add(crc, VECS[v].addr[7:0]);
        crc = crc_add(crc, VECS[v].addr[15:8]);
        for (int i = 0; i < 8; i++) begin
          send(VECS[v].seed + 8'(i));
          crc = crc_add(crc, VECS[v].seed + 8'(i));
          exp_sp[i] = memval({VECS[v].addr[15:3], 3'(i)});
        end
        chk(st_count == 3'd7, "R6 count holds at 7", {29'h0, st_count}, 7);
        sp_match("R6 row loaded");
        recv(b); chk(b == ~crc[7:0],  "R7 crc low",  {24'h0, b}, {24'h0, ~crc[7:0]});
        recv(b); chk(b == ~crc[15:8], "R7 crc high", {24'h0, b}, {24'h0, ~crc[15:8]});
        recv(b); chk(b == 8'hFF, "R8 ones after crc", {24'h0, b}, 32'hFF);
        chk(st_aa == VECS[v].aa, "R9 authorization", {31'h0, st_aa}, {31'h0, VECS[v].aa});
        prev_aa = VECS[v].aa;
      end else begin
        chk(tx_data == 8'hFF, "R5 reject returns ones", {24'h0, tx_data}, 32'hFF);
        send(8'h99); send(8'h66);
        chk({st_count, st_aa, st_pf} == {3'd7, prev_aa, 1'b0}, "R5 status untouched",
            {27'h0, st_count, st_aa, st_pf}, {27'h0, 3'd7, prev_aa, 1'b0});
        sp_match("R5 scratchpad untouched");
      end
    end

    // R8 bytes after the crc are ignored
    send(8'h44);
    chk(st_count == 3'd7 && tx_data == 8'hFF, "R8 ignored byte", {21'h0, st_count, tx_data}, 32'h7FF);
    sp_match("R8 scratchpad kept");

    // R10 / R11 abort with a partial byte mid-row
    abort(1'b0);
    send(8'hA3); send(8'h40); send(8'h00);
    for (int i = 0; i < 3; i++) begin
      send(8'h20 + 8'(i));
      exp_sp[i] = memval({13'h0008, 3'(i)});
    end
    abort(1'b1);
    chk(st_pf, "R10 partial abort sets flag", {31'h0, st_pf}, 1);
    chk(!cmd_active && tx_data == 8'hFF, "R11 abort to idle", {23'h0, cmd_active, tx_data}, 32'hFF);
    sp_match("R11 loaded and old bytes kept");
    abort(1'b1);
    chk(st_pf, "R10 idle abort leaves flag", {31'h0, st_pf}, 1);

    // R10 whole-byte abort does not set the flag
    send(8'hA3); send(8'h40); send(8'h00);
    send(8'h31);
    exp_sp[0] = memval(16'h0040);
    abort(1'b0);
    chk(!st_pf, "R10 clean abort no flag", {31'h0, st_pf}, 0);
    sp_match("R11 clean abort keeps bytes");

    // R11 abort during crc phase
    send(8'hA3); send(8'h08); send(8'h00);
    for (int i = 0; i < 8; i++) begin
      send(8'h01);
      exp_sp[i] = memval({13'h0001, 3'(i)});
    end
    abort(1'b0);
    chk(!cmd_active && tx_data == 8'hFF, "R11 abort in crc", {23'h0, cmd_active, tx_data}, 32'hFF);
    chk(st_aa, "R9 low target sets flag", {31'h0, st_aa}, 1);
    sp_match("R6 row at 0008h");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule